// File: doc/BRIEF.md
# Five-Port Wormhole Mesh Router

This block is the switching element of one tile in a two-dimensional mesh. It carries flits between the four neighbouring tiles (east, west, north, south) and the local processing core. Every port has a valid/ready handshake in each direction. Arriving flits are queued in a small per-port buffer. A packet at the head of a buffer then passes through three pipelined steps. First a route lookup chooses the output. Then a per-output round-robin arbiter picks one of the contending inputs. Finally the winner's flits cross a five-by-five crossbar into an output register.

Packets are made of a head flit, optional body flits and a tail flit. A one-flit packet carries a single kind that is both head and tail. The head flit names the destination tile by X and Y coordinates. The tile's own coordinates are parameters. Once an output is granted it stays with that input until the tail flit has crossed (wormhole switching), so flits of different packets never mix on one output. Route lookup, arbitration and transfer are separate register stages, so one input can be routing while another is streaming body flits.

Top module: `noc_mesh_router`

## Requirements
- R1: Port index i of every per-port bus has a fixed meaning: 0 = east (+X), 1 = west (-X), 2 = north (+Y), 3 = south (-Y), 4 = local core. Port i's flit occupies bits [i*(DATA_W+2) +: DATA_W+2] of the flit buses.
- R2: A head flit holds its destination X in bits [COORD_W-1:0] and its destination Y in bits [2*COORD_W-1:COORD_W]. Routing is dimension-ordered. If X is larger than MY_X the packet goes to port 0, and if smaller to port 1. When X is equal, a Y larger than MY_Y goes to port 2 and a smaller Y to port 3. When both are equal the packet goes to port 4.
- R3: Each input buffer holds FIFO_DEPTH flits in arrival order. in_ready for a port is low exactly while its buffer is full. With the output stalled, a depth-4 buffer plus the output register absorbs five flits of a packet and then holds in_ready low.
- R4: On an idle router with out_ready high, the output shows a head flit accepted at clock edge k as out_valid high after edge k+3, and not before.
- R5: An output stays with its granted input until that input's tail flit has crossed. Flits of another packet never appear between a head and its tail on one output.
- R6: Each output arbitrates round-robin. The most recently granted input gets the lowest priority, and after reset input 0 has the highest priority.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_flit stays unchanged.
- R8: Once a packet holds its output and out_ready is high, its flits leave one per cycle. Packets bound for different outputs travel at the same time.
- R9: During reset and right after it, all in_ready bits are high and all out_valid bits are low.
- R10: The two top bits of a flit give its kind: 2'b01 head, 2'b00 body, 2'b10 tail, 2'b11 single-flit packet (both head and tail).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 5 | Per-port flit offered by the upstream side |
| in_ready | output | 5 | Per-port buffer has room |
| in_flit | input | 5*(DATA_W+2) | Incoming flits, one slice per port |
| out_valid | output | 5 | Per-port flit presented downstream |
| out_ready | input | 5 | Downstream side accepts the flit |
| out_flit | output | 5*(DATA_W+2) | Outgoing flits, one slice per port |

## Verification
The bench builds the router with MY_X = 1 and MY_Y = 1 and two-bit coordinates. Destinations can then lie on both sides of the tile in each dimension, so all five route outcomes and the X-before-Y ordering can be reached. The bench keeps FIFO_DEPTH at 4, so filling a buffer behind a stalled output takes only a few flits. With DATA_W at 16 there is room for a 12-bit tag in every flit. This tag shows which input and which packet a flit came from when the arbitration order and packet contiguity are checked.

// File: rtl/noc_rtr_pkg.sv
`timescale 1ns/1ps
package noc_rtr_pkg;
  localparam int NPORT  = 5;
  localparam int PORT_W = $clog2(NPORT);

  // fixed port meaning, shared with the neighbours' wiring
  localparam logic [PORT_W-1:0] PORT_EAST  = 3'd0;
  localparam logic [PORT_W-1:0] PORT_WEST  = 3'd1;
  localparam logic [PORT_W-1:0] PORT_NORTH = 3'd2;
  localparam logic [PORT_W-1:0] PORT_SOUTH = 3'd3;
  localparam logic [PORT_W-1:0] PORT_CORE  = 3'd4;

  // flit kind code, bit 0 = opens a packet, bit 1 = closes a packet
  localparam logic [1:0] KIND_BODY = 2'b00;
  localparam logic [1:0] KIND_HEAD = 2'b01;
  localparam logic [1:0] KIND_TAIL = 2'b10;
  localparam logic [1:0] KIND_SOLO = 2'b11;

  function automatic logic kind_opens(input logic [1:0] k);
    return k[0];
  endfunction

  function automatic logic kind_closes(input logic [1:0] k);
    return k[1];
  endfunction

  // dimension-ordered choice: settle X, then Y, then eject
  function automatic logic [PORT_W-1:0] xy_pick(input int dx, input int dy,
                                                input int mx, input int my);
    if (dx > mx) return PORT_EAST;
    if (dx < mx) return PORT_WEST;
    if (dy > my) return PORT_NORTH;
    if (dy < my) return PORT_SOUTH;
    return PORT_CORE;
  endfunction
endpackage

// File: rtl/rtr_in_fifo.sv
`timescale 1ns/1ps
module rtr_in_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  AST_FIFO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (cnt == $past(cnt) + CW'(1))); // R3
  AST_FIFO_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R3
endmodule

// File: rtl/rtr_rr_arb.sv
`timescale 1ns/1ps
module rtr_rr_arb #(
  parameter int N = 5,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] last_q;

  // search starts one past the last winner
  always_comb begin
    int idx;
    logic found;
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    idx     = 0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last_q) + k) % N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        gnt_idx  = IW'(idx);
        found    = 1'b1;
      end
    end
    if (!take) begin
      gnt = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                last_q <= IW'(N - 1);
    else if (take && (|gnt))   last_q <= gnt_idx;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R6
  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt & ~req) == '0)); // R6
endmodule

// File: rtl/noc_mesh_router.sv
`timescale 1ns/1ps
module noc_mesh_router
  import noc_rtr_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int COORD_W    = 2,
  parameter int FIFO_DEPTH = 4,
  parameter int MY_X       = 1,
  parameter int MY_Y       = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPORT-1:0]              in_valid,
  output logic [NPORT-1:0]              in_ready,
  input  logic [NPORT*(DATA_W+2)-1:0]   in_flit,
  output logic [NPORT-1:0]              out_valid,
  input  logic [NPORT-1:0]              out_ready,
  output logic [NPORT*(DATA_W+2)-1:0]   out_flit
);
  localparam int FW = DATA_W + 2;
  localparam int DW = 2 * COORD_W;

  typedef enum logic [1:0] {IN_IDLE, IN_ROUTED, IN_GRANTED} in_st_e;

  function automatic logic [PORT_W-1:0] route_of(input logic [DW-1:0] d);
    return xy_pick(int'(d[COORD_W-1:0]), int'(d[DW-1:COORD_W]), MY_X, MY_Y);
  endfunction

  // per-input state
  logic [FW-1:0]     hd       [NPORT];
  in_st_e            st_q     [NPORT];
  logic [PORT_W-1:0] route_q  [NPORT];
  logic [NPORT-1:0]  f_empty, f_full, push, pop;
  logic [NPORT-1:0]  route_load, grant_any, tail_done;

  // per-output state
  logic [NPORT-1:0]  lock_v;
  logic [PORT_W-1:0] lock_id  [NPORT];
  logic [NPORT-1:0]  req_o    [NPORT];
  logic [NPORT-1:0]  gnt_o    [NPORT];
  logic [PORT_W-1:0] gidx     [NPORT];
  logic [FW-1:0]     sel_flit [NPORT];
  logic [NPORT-1:0]  xfer, xfer_tail;
  logic [NPORT-1:0]  ov_q;
  logic [FW-1:0]     of_q     [NPORT];
  logic [NPORT-1:0]  owns     [NPORT];

  // stage 0: input buffers
  for (genvar gi = 0; gi < NPORT; gi++) begin : g_in
    assign push[gi] = in_valid[gi] & ~f_full[gi];
    rtr_in_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push[gi]),
      .din   (in_flit[gi*FW +: FW]),
      .pop   (pop[gi]),
      .dout  (hd[gi]),
      .empty (f_empty[gi]),
      .full  (f_full[gi])
    );
  end
  assign in_ready = ~f_full;

  // stage 1 event: a fresh head is waiting for a route
  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      route_load[i] = (st_q[i] == IN_IDLE) && !f_empty[i] && kind_opens(hd[i][FW-1 -: 2]);
    end
  end

  // stage 2: requests toward free outputs
  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      req_o[o] = '0;
      for (int i = 0; i < NPORT; i++) begin
        req_o[o][i] = (st_q[i] == IN_ROUTED) && (route_q[i] == PORT_W'(o)) && !lock_v[o];
      end
    end
  end

  for (genvar go = 0; go < NPORT; go++) begin : g_arb
    rtr_rr_arb #(.N(NPORT), .IW(PORT_W)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req_o[go]),
      .take    (!lock_v[go]),
      .gnt     (gnt_o[go]),
      .gnt_idx (gidx[go])
    );
  end

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      grant_any[i] = 1'b0;
      for (int o = 0; o < NPORT; o++) grant_any[i] = grant_any[i] | gnt_o[o][i];
    end
  end

  // stage 3: crossbar transfer into the output registers
  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      sel_flit[o]  = hd[lock_id[o]];
      xfer[o]      = lock_v[o] && !f_empty[lock_id[o]] && (!ov_q[o] || out_ready[o]);
      xfer_tail[o] = xfer[o] && kind_closes(sel_flit[o][FW-1 -: 2]);
    end
    for (int i = 0; i < NPORT; i++) begin
      pop[i] = 1'b0;
      for (int o = 0; o < NPORT; o++) begin
        if (xfer[o] && (lock_id[o] == PORT_W'(i))) pop[i] = 1'b1;
      end
      tail_done[i] = pop[i] && kind_closes(hd[i][FW-1 -: 2]);
    end
  end

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      for (int o = 0; o < NPORT; o++) owns[i][o] = lock_v[o] && (lock_id[o] == PORT_W'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPORT; i++) begin
        st_q[i]    <= IN_IDLE;
        route_q[i] <= '0;
      end
      for (int o = 0; o < NPORT; o++) begin
        lock_id[o] <= '0;
        of_q[o]    <= '0;
      end
      lock_v <= '0;
      ov_q   <= '0;
    end else begin
      for (int i = 0; i < NPORT; i++) begin
        if (route_load[i]) begin
          st_q[i]    <= IN_ROUTED;
          route_q[i] <= route_of(hd[i][DW-1:0]);
        end else if (grant_any[i]) begin
          st_q[i] <= IN_GRANTED;
        end else if (tail_done[i]) begin
          st_q[i] <= IN_IDLE;
        end
      end
      for (int o = 0; o < NPORT; o++) begin
        if (xfer_tail[o]) begin
          lock_v[o] <= 1'b0;
        end else if (|gnt_o[o]) begin
          lock_v[o]  <= 1'b1;
          lock_id[o] <= gidx[o];
        end
        if (xfer[o]) begin
          ov_q[o] <= 1'b1;
          of_q[o] <= sel_flit[o];
        end else if (out_ready[o]) begin
          ov_q[o] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    out_valid = ov_q;
    for (int o = 0; o < NPORT; o++) out_flit[o*FW +: FW] = of_q[o];
  end

  for (genvar go = 0; go < NPORT; go++) begin : g_chk_out
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[go] && !out_ready[go]) |=> (out_valid[go] && $stable(out_flit[go*FW +: FW]))); // R7
    AST_STALL_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[go] && !out_ready[go]) |-> !xfer[go]); // R7
    AST_TAIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock_v[go]) |-> $past(xfer_tail[go])); // R5
  end

  for (genvar gi = 0; gi < NPORT; gi++) begin : g_chk_in
    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(owns[gi]) <= 1)); // R5
  end

  AST_EJECT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer[PORT_CORE] && kind_opens(sel_flit[PORT_CORE][FW-1 -: 2])) |->
    ((int'(sel_flit[PORT_CORE][COORD_W-1:0]) == MY_X) &&
     (int'(sel_flit[PORT_CORE][DW-1:COORD_W]) == MY_Y))); // R2
endmodule

// File: tb/noc_mesh_router_tb.sv
`timescale 1ns/1ps
module noc_mesh_router_tb_top;
  localparam int NP = 5;
  localparam int FW = 18;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NP-1:0]      in_valid = '0;
  logic [NP-1:0]      in_ready;
  logic [NP*FW-1:0]   in_flit = '0;
  logic [NP-1:0]      out_valid;
  logic [NP-1:0]      out_ready = '1;
  logic [NP*FW-1:0]   out_flit;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [FW-1:0] got  [NP][16];
  int            gcyc [NP][16];
  int            gcnt [NP];

  always #4 clk = ~clk;

  noc_mesh_router #(.DATA_W(16), .COORD_W(2), .FIFO_DEPTH(4), .MY_X(1), .MY_Y(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
    .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit));

  // kind codes: 01 head, 00 body, 10 tail, 11 solo (R10)
  function automatic logic [FW-1:0] mk(input logic [1:0] k, input logic [11:0] tag,
                                       input logic [1:0] dx, input logic [1:0] dy);
    return {k, tag, dy, dx};
  endfunction

  // record every handshake completed at the coming edge
  always begin
    @(negedge clk);
    #2;
    cyc = cyc + 1;
    for (int o = 0; o < NP; o++) begin
      if (out_valid[o] && out_ready[o]) begin
        if (gcnt[o] < 16) begin
          got[o][gcnt[o]]  = out_flit[o*FW +: FW];
          gcyc[o][gcnt[o]] = cyc;
        end
        gcnt[o] = gcnt[o] + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clr();
    for (int o = 0; o < NP; o++) gcnt[o] = 0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // called at a negedge; returns at the negedge after the flit is taken
  task automatic drive(input int p, input logic [FW-1:0] f);
    in_valid[p] = 1'b1;
    in_flit[p*FW +: FW] = f;
    while (!in_ready[p]) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_pkt(input int p, input int len, input logic [11:0] tag0,
                          input logic [1:0] dx, input logic [1:0] dy);
    for (int k = 0; k < len; k++) begin
      logic [1:0] kd;
      kd = (k == 0) ? 2'b01 : ((k == len - 1) ? 2'b10 : 2'b00);
      drive(p, mk(kd, tag0 + 12'(k), (k == 0) ? dx : 2'd0, (k == 0) ? dy : 2'd0));
    end
    in_valid[p] = 1'b0;
  endtask

  // {input port, dest x, dest y, expected output}; tile sits at (1,1)
  localparam logic [9:0] VEC [8] = '{
    {3'd4, 2'd3, 2'd1, 3'd0},
    {3'd1, 2'd2, 2'd0, 3'd0},
    {3'd0, 2'd0, 2'd3, 3'd1},
    {3'd4, 2'd1, 2'd2, 3'd2},
    {3'd3, 2'd1, 2'd3, 3'd2},
    {3'd2, 2'd1, 2'd0, 3'd3},
    {3'd0, 2'd1, 2'd1, 3'd4},
    {3'd1, 2'd0, 2'd0, 3'd1}
  };

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    clr();
    idle(3);
    // R9: reset state
    chk(in_ready == 5'h1f, "R9", "in_ready during reset", in_ready, 5'h1f);
    chk(out_valid == 5'h00, "R9", "out_valid during reset", out_valid, 0);
    rst_n = 1'b1;
    idle(2);
    chk(in_ready == 5'h1f && out_valid == 5'h00, "R9", "state after reset",
        {in_ready, out_valid}, 10'h3e0);

    // R1 R2 R10: route table walk
    for (int v = 0; v < 8; v++) begin
      int p, ex, tot;
      logic [FW-1:0] f;
      p  = int'(VEC[v][9:7]);
      ex = int'(VEC[v][2:0]);
      f  = mk(2'b11, 12'(16'h100 + v), VEC[v][6:5], VEC[v][4:3]);
      clr();
      drive(p, f);
      in_valid[p] = 1'b0;
      idle(6);
      tot = 0;
      for (int o = 0; o < NP; o++) tot += gcnt[o];
      chk(gcnt[ex] == 1 && tot == 1, "R2", "route output count", tot, 1);
      chk(got[ex][0] == f, "R1", "flit on routed port", got[ex][0], f);
    end

    // R4: head latency on idle router
    clr();
    in_valid[4] = 1'b1;
    in_flit[4*FW +: FW] = mk(2'b11, 12'h0aa, 2'd1, 2'd1);
    @(negedge clk);
    in_valid[4] = 1'b0;
    idle(2);
    chk(out_valid[4] == 1'b0, "R4", "out_valid after edge k+2", out_valid[4], 0);
    idle(1);
    chk(out_valid[4] == 1'b1, "R4", "out_valid after edge k+3", out_valid[4], 1);
    idle(3);

    // R3 R7 R8: fill buffer behind a stalled output
    clr();
    out_ready[0] = 1'b0;
    fork
      send_pkt(1, 6, 12'h001, 2'd3, 2'd1);
      begin
        idle(12);
        chk(in_ready[1] == 1'b0, "R3", "in_ready when buffer full", in_ready[1], 0);
        chk(out_valid[0] == 1'b1, "R7", "out_valid held while stalled", out_valid[0], 1);
        chk(out_flit[0 +: FW] == mk(2'b01, 12'h001, 2'd3, 2'd1), "R7", "stalled flit stable",
            out_flit[0 +: FW], mk(2'b01, 12'h001, 2'd3, 2'd1));
        chk(gcnt[0] == 0, "R7", "no transfer while stalled", gcnt[0], 0);
        out_ready[0] = 1'b1;
      end
    join
    idle(12);
    chk(gcnt[0] == 6, "R3", "flits delivered", gcnt[0], 6);
    for (int k = 0; k < 6; k++) begin
      chk(got[0][k][15:4] == 12'(k + 1), "R3", "flit order", got[0][k][15:4], k + 1);
    end
    chk(gcyc[0][5] - gcyc[0][0] == 5, "R8", "one flit per cycle", gcyc[0][5] - gcyc[0][0], 5);

    // R5 R6: round robin after input 2 holds the core output
    clr();
    out_ready[4] = 1'b0;
    send_pkt(2, 2, 12'h021, 2'd1, 2'd1);
    idle(4);
    fork
      send_pkt(1, 2, 12'h011, 2'd1, 2'd1);
      send_pkt(3, 2, 12'h031, 2'd1, 2'd1);
    join
    idle(6);
    out_ready[4] = 1'b1;
    idle(20);
    chk(gcnt[4] == 6, "R5", "flits at core port", gcnt[4], 6);
    begin
      logic [11:0] exp_tag [6];
      exp_tag = '{12'h021, 12'h022, 12'h031, 12'h032, 12'h011, 12'h012};
      for (int k = 0; k < 6; k++) begin
        chk(got[4][k][15:4] == exp_tag[k], (k == 2) ? "R6" : "R5", "packet order at core",
            got[4][k][15:4], exp_tag[k]);
      end
    end

    // R8: two packets to different outputs in parallel
    clr();
    fork
      send_pkt(4, 3, 12'h041, 2'd3, 2'd1);
      send_pkt(0, 3, 12'h051, 2'd1, 2'd3);
    join
    idle(8);
    chk(gcnt[0] == 3 && gcnt[2] == 3, "R8", "both packets delivered", gcnt[0] + gcnt[2], 6);
    chk(gcyc[0][0] == gcyc[2][0], "R8", "heads leave together", gcyc[0][0], gcyc[2][0]);
    chk(gcyc[2][2] - gcyc[2][0] == 2, "R8", "body streams", gcyc[2][2] - gcyc[2][0], 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule